// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Controller

This block supervises a processor. One reset output is driven from three causes: the initial power-up, a supply that falls below its threshold, and expiry of a watchdog timer. The analog comparator is outside the block. A digital `supply_ok` input reports whether the supply is above its threshold. Reset stays asserted until the supply has been valid without a break for a hold period, which is nominally 200 ms. A watchdog expiry also starts that same hold period. A parameterised clock prescaler produces a tick, and every interval in the block counts these ticks. This lets a bench shrink milliseconds to a few cycles.

The processor keeps the watchdog alive by issuing a start condition on the two-wire bus it shares with a companion serial memory. A start condition is a falling data line while the clock line is high. A three-bit control register selects the watchdog interval or disables the watchdog. The register also carries a lock-enable bit, which, together with a write-protect pin, freezes the register. The register models nonvolatile storage. An accepted write occupies a timed write cycle before it takes effect. A cycle that is already running always completes. A new cycle cannot start while reset is active. While reset is active, a bus-inhibit output tells the companion memory interface to abort traffic and accept no new traffic.

Top module: `sup_reset_ctrl`

## Requirements
- R1: The watchdog count restarts only when the synchronised data line falls while the synchronised clock line is high. Data edges while the clock is low, and a rising data edge while the clock is high, leave the count running.
- R2: With the watchdog enabled and no start condition, reset asserts the selected number of ticks after the last start, or after the count began, within one tick.
- R3: A low `supply_ok` asserts reset within four clocks. Reset releases only after `supply_ok` has stayed high for HOLD_TICKS ticks without a break, and a dip during the hold restarts the hold.
- R4: After `rst_n` is released, reset is asserted at once. It releases HOLD_TICKS ticks, within one tick, after `supply_ok` goes high.
- R5: Control bits [1:0] select the watchdog interval: 00 gives WD_LONG_TICKS, 01 gives WD_MID_TICKS, 10 gives WD_SHORT_TICKS, and 11 disables the watchdog so that it never asserts reset.
- R6: `bus_inhibit` is high whenever reset is active. A watchdog expiry holds reset for HOLD_TICKS ticks before release.
- R7: A control write is rejected and starts no write cycle when `wp_pin` is high and control bit 2 (lock enable) is set. With `wp_pin` low, the write is accepted.
- R8: An accepted write commits to `cfg_rdata` NV_WR_TICKS ticks later, even if reset asserts during the cycle. A write presented while reset is active is ignored.
- R9: The watchdog count is cleared and held while reset is active. It counts the full interval only from the release of reset.
- R10: With ACTIVE_LOW set, `rst_out` is low during reset. With ACTIVE_LOW clear, it is high during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-application reset, active low |
| supply_ok | input | 1 | High when the supply is above its threshold (asynchronous) |
| scl_in | input | 1 | Two-wire bus clock line (asynchronous) |
| sda_in | input | 1 | Two-wire bus data line (asynchronous) |
| wp_pin | input | 1 | Write-protect pin, sampled together with the write strobe |
| cfg_we | input | 1 | Control register write strobe, one clock |
| cfg_wdata | input | 3 | Write data: bit 2 lock enable, bits 1:0 watchdog select |
| cfg_rdata | output | 3 | Committed control register contents |
| nv_busy | output | 1 | A control write cycle is in progress |
| bus_inhibit | output | 1 | Abort and refuse bus traffic (reset active) |
| rst_out | output | 1 | Reset output, polarity set by ACTIVE_LOW |

## Verification
The hardest case to reach is a write cycle that is already running when reset arrives. The bench issues an accepted write and drops `supply_ok` on the very next clock. It then watches `nv_busy` stay high through the reset and checks that the new value still commits. A second case is a start condition hidden among look-alike bus activity. The bench drives one genuine falling edge and follows it with data toggles while the clock is low and a stop-like rising edge. The expiry time is then measured from the genuine edge alone. A hold that is never allowed to complete is produced by dropping the supply halfway through it, and the release is timed from the final rise.

// File: rtl/sup_pkg.sv
package sup_pkg;

   // Watchdog interval selection carried in control bits [1:0]
   typedef enum logic [1:0] {
      WD_SEL_LONG  = 2'b00,
      WD_SEL_MID   = 2'b01,
      WD_SEL_SHORT = 2'b10,
      WD_SEL_OFF   = 2'b11
   } wd_sel_e;

   // Control register image; lock enable sits in bit 2
   typedef struct packed {
      logic    lock_en;
      wd_sel_e sel;
   } ctl_t;

   localparam int unsigned CTL_W = $bits(ctl_t);

endpackage

// File: rtl/sup_sync.sv
// Multi-stage synchroniser for one asynchronous level
module sup_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RST_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d};
      end
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/sup_timebase.sv
// Prescaler: one-cycle tick every PRESCALE clocks
module sup_timebase #(
   parameter int unsigned PRESCALE = 200000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);

   localparam int unsigned PW = $clog2(PRESCALE);

   logic [PW-1:0] div_q;

   assign tick = (div_q == PW'(PRESCALE - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
      end else if (tick) begin
         div_q <= '0;
      end else begin
         div_q <= div_q + 1'b1;
      end
   end

endmodule

// File: rtl/sup_hold.sv
// Reset state and hold counter shared by supply and watchdog causes
module sup_hold #(
   parameter int unsigned HOLD_TICKS = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok_s,
   input  logic tick,
   input  logic restart,
   output logic active
);

   localparam int unsigned HW = $clog2(HOLD_TICKS);

   logic [HW-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b1;
         hold_q <= '0;
      end else if (!supply_ok_s || restart) begin
         active <= 1'b1;
         hold_q <= '0;
      end else if (active && tick) begin
         if (hold_q == HW'(HOLD_TICKS - 1)) begin
            active <= 1'b0;
            hold_q <= '0;
         end else begin
            hold_q <= hold_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/sup_start_det.sv
// Start condition: data falls while clock is high (synchronised inputs)
module sup_start_det (
   input  logic clk,
   input  logic rst_n,
   input  logic sda_s,
   input  logic scl_s,
   output logic start
);

   logic sda_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sda_prev_q <= 1'b1;
      end else begin
         sda_prev_q <= sda_s;
      end
   end

   assign start = sda_prev_q & ~sda_s & scl_s;

endmodule

// File: rtl/sup_wdog.sv
// Watchdog counter with selectable limit
module sup_wdog
   import sup_pkg::*;
#(
   parameter int unsigned LONG_TICKS  = 1400,
   parameter int unsigned MID_TICKS   = 600,
   parameter int unsigned SHORT_TICKS = 200,
   parameter int unsigned CW          = $clog2(LONG_TICKS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          kick,
   input  logic          hold,
   input  wd_sel_e       sel,
   output logic          fire,
   output logic [CW-1:0] cnt_q
);

   logic [CW-1:0] limit;
   logic          enabled;

   always_comb begin
      enabled = 1'b1;
      unique case (sel)
         WD_SEL_LONG:  limit = CW'(LONG_TICKS);
         WD_SEL_MID:   limit = CW'(MID_TICKS);
         WD_SEL_SHORT: limit = CW'(SHORT_TICKS);
         default: begin
            limit   = CW'(LONG_TICKS);
            enabled = 1'b0;
         end
      endcase
   end

   // >= so that a switch to a shorter interval fires promptly
   assign fire = enabled & ~hold & tick & (cnt_q >= limit - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (hold || kick || !enabled || fire) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/sup_ctl_reg.sv
// Control register with timed (nonvolatile-style) write cycle and lock
module sup_ctl_reg
   import sup_pkg::*;
#(
   parameter int unsigned      NV_WR_TICKS = 5,
   parameter logic [CTL_W-1:0] INIT_CFG    = '0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic we,
   input  ctl_t wdata,
   input  logic wp_pin,
   input  logic blocked,
   output ctl_t ctl_q,
   output logic busy
);

   localparam int unsigned NW = $clog2(NV_WR_TICKS);

   ctl_t          pend_q;
   logic [NW-1:0] wr_cnt_q;
   logic          locked;
   logic          accept;

   assign locked = wp_pin & ctl_q.lock_en;
   assign accept = we & ~locked & ~blocked & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q    <= ctl_t'(INIT_CFG);
         pend_q   <= ctl_t'(INIT_CFG);
         busy     <= 1'b0;
         wr_cnt_q <= '0;
      end else if (accept) begin
         pend_q   <= wdata;
         busy     <= 1'b1;
         wr_cnt_q <= '0;
      end else if (busy && tick) begin
         if (wr_cnt_q == NW'(NV_WR_TICKS - 1)) begin
            ctl_q    <= pend_q;
            busy     <= 1'b0;
            wr_cnt_q <= '0;
         end else begin
            wr_cnt_q <= wr_cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl
   import sup_pkg::*;
#(
   parameter int unsigned      PRESCALE       = 200000,
   parameter int unsigned      HOLD_TICKS     = 200,
   parameter int unsigned      WD_LONG_TICKS  = 1400,
   parameter int unsigned      WD_MID_TICKS   = 600,
   parameter int unsigned      WD_SHORT_TICKS = 200,
   parameter int unsigned      NV_WR_TICKS    = 5,
   parameter int unsigned      SYNC_STAGES    = 2,
   parameter bit               ACTIVE_LOW     = 1'b1,
   parameter logic [CTL_W-1:0] INIT_CFG       = 3'b000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             supply_ok,
   input  logic             scl_in,
   input  logic             sda_in,
   input  logic             wp_pin,
   input  logic             cfg_we,
   input  logic [CTL_W-1:0] cfg_wdata,
   output logic [CTL_W-1:0] cfg_rdata,
   output logic             nv_busy,
   output logic             bus_inhibit,
   output logic             rst_out
);

   localparam int unsigned WD_W = $clog2(WD_LONG_TICKS + 1);

   // Elaboration-time parameter checks
   generate
      if (PRESCALE < 2) begin : g_bad_prescale
         $error("PRESCALE must be at least 2");
      end
      if (HOLD_TICKS < 2) begin : g_bad_hold
         $error("HOLD_TICKS must be at least 2");
      end
      if (NV_WR_TICKS < 2) begin : g_bad_nv
         $error("NV_WR_TICKS must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (!(WD_LONG_TICKS > WD_MID_TICKS && WD_MID_TICKS > WD_SHORT_TICKS
            && WD_SHORT_TICKS >= 2)) begin : g_bad_wd
         $error("watchdog intervals must be strictly decreasing and at least 2");
      end
   endgenerate

   logic            supply_s;
   logic            sda_s;
   logic            scl_s;
   logic            tick;
   logic            start;
   logic            wd_fire;
   logic            reset_active;
   logic [WD_W-1:0] wd_cnt;
   ctl_t            ctl;

   sup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sup (
      .clk(clk), .rst_n(rst_n), .d(supply_ok), .q(supply_s));
   sup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));
   sup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));

   sup_timebase #(.PRESCALE(PRESCALE)) u_tb (
      .clk(clk), .rst_n(rst_n), .tick(tick));

   sup_start_det u_start (
      .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_s(scl_s), .start(start));

   sup_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
      .clk(clk), .rst_n(rst_n), .supply_ok_s(supply_s), .tick(tick),
      .restart(wd_fire), .active(reset_active));

   sup_wdog #(
      .LONG_TICKS(WD_LONG_TICKS), .MID_TICKS(WD_MID_TICKS),
      .SHORT_TICKS(WD_SHORT_TICKS), .CW(WD_W)
   ) u_wd (
      .clk(clk), .rst_n(rst_n), .tick(tick), .kick(start),
      .hold(reset_active), .sel(ctl.sel), .fire(wd_fire), .cnt_q(wd_cnt));

   sup_ctl_reg #(.NV_WR_TICKS(NV_WR_TICKS), .INIT_CFG(INIT_CFG)) u_ctl (
      .clk(clk), .rst_n(rst_n), .tick(tick), .we(cfg_we),
      .wdata(ctl_t'(cfg_wdata)), .wp_pin(wp_pin), .blocked(reset_active),
      .ctl_q(ctl), .busy(nv_busy));

   assign cfg_rdata   = ctl;
   assign bus_inhibit = reset_active;

   generate
      if (ACTIVE_LOW) begin : g_out_low
         assign rst_out = ~reset_active;
      end else begin : g_out_high
         assign rst_out = reset_active;
      end
   endgenerate

endmodule

// File: rtl/sup_reset_ctrl_chk.sv
module sup_reset_ctrl_chk #(
   parameter bit          ACTIVE_LOW = 1'b1,
   parameter int unsigned CW         = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          supply_ok,
   input logic          rst_out,
   input logic          bus_inhibit,
   input logic          nv_busy,
   input logic          cfg_we,
   input logic          wp_pin,
   input logic          cfg_lock_en,
   input logic [CW-1:0] wd_cnt
);

   logic rst_act;
   assign rst_act = ACTIVE_LOW ? ~rst_out : rst_out;

   // R3
   supply_low_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!supply_ok && !$past(supply_ok) && !$past(supply_ok, 2) && !$past(supply_ok, 3))
      |-> rst_act);

   // R6
   inhibit_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_act |-> bus_inhibit);

   // R7
   locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && wp_pin && cfg_lock_en) |=> !$rose(nv_busy));

   // R8
   no_write_start_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nv_busy) |-> $past(!bus_inhibit));

   // R9
   wd_held_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_act && $past(rst_act)) |-> (wd_cnt == '0));

endmodule

bind sup_reset_ctrl sup_reset_ctrl_chk #(.ACTIVE_LOW(ACTIVE_LOW), .CW(WD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .rst_out(rst_out),
   .bus_inhibit(bus_inhibit), .nv_busy(nv_busy), .cfg_we(cfg_we),
   .wp_pin(wp_pin), .cfg_lock_en(cfg_rdata[2]), .wd_cnt(wd_cnt));

// File: tb/sup_reset_ctrl_bench.sv
module sup_reset_ctrl_bench;

   localparam int P     = 4;
   localparam int HOLD  = 20;
   localparam int LONG  = 60;
   localparam int MID   = 40;
   localparam int SHORT = 25;
   localparam int NV    = 6;

   logic       clk = 1'b0;
   logic       rst_n, supply_ok, scl_in, sda_in, wp_pin, cfg_we;
   logic [2:0] cfg_wdata;
   logic [2:0] cfg_rdata, cfg_rdata_hi;
   logic       nv_busy, nv_busy_hi, bus_inhibit, bus_inhibit_hi;
   logic       rst_out_lo, rst_out_hi;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   sup_reset_ctrl #(
      .PRESCALE(P), .HOLD_TICKS(HOLD), .WD_LONG_TICKS(LONG), .WD_MID_TICKS(MID),
      .WD_SHORT_TICKS(SHORT), .NV_WR_TICKS(NV), .ACTIVE_LOW(1'b1), .INIT_CFG(3'b011)
   ) u_sup_reset_ctrl (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .scl_in(scl_in), .sda_in(sda_in),
      .wp_pin(wp_pin), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .nv_busy(nv_busy), .bus_inhibit(bus_inhibit), .rst_out(rst_out_lo));

   sup_reset_ctrl #(
      .PRESCALE(P), .HOLD_TICKS(HOLD), .WD_LONG_TICKS(LONG), .WD_MID_TICKS(MID),
      .WD_SHORT_TICKS(SHORT), .NV_WR_TICKS(NV), .ACTIVE_LOW(1'b0), .INIT_CFG(3'b011)
   ) u_hi (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .scl_in(scl_in), .sda_in(sda_in),
      .wp_pin(wp_pin), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata_hi),
      .nv_busy(nv_busy_hi), .bus_inhibit(bus_inhibit_hi), .rst_out(rst_out_hi));

   function automatic bit in_reset();
      return (rst_out_lo == 1'b0);
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic measure(input bit want, input int maxc, output int n);
      n = 0;
      while (in_reset() != want && n < maxc) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic check_window(input string req, input string what,
                               input int n, input int nominal);
      check(n >= nominal - P - 2 && n <= nominal + P + 6, req, what, n, nominal);
   endtask

   task automatic check_pol(input string where);
      // R10 both variants agree on the reset state with opposite levels
      check(rst_out_hi == ~rst_out_lo, "R10", where, rst_out_hi, ~rst_out_lo);
      // R6 inhibit follows reset
      check(bus_inhibit == in_reset(), "R6", where, bus_inhibit, in_reset());
   endtask

   task automatic write_cfg(input logic [2:0] v);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_wdata = v;
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic wait_nv();
      int n = 0;
      while (nv_busy && n < (NV + 2) * P) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic start_fall();
      scl_in = 1'b1;
      sda_in = 1'b1;
      cyc(3);
      sda_in = 1'b0;
   endtask

   task automatic bus_idle();
      cyc(2);
      sda_in = 1'b1;
      cyc(2);
   endtask

   task automatic t_reset_state();
      check(in_reset(), "R4", "reset active after power-up", rst_out_lo, 0);
      check(cfg_rdata == 3'b011, "R5", "initial control value", cfg_rdata, 3);
      check(!nv_busy, "R8", "no write cycle at power-up", nv_busy, 0);
      check_pol("power-up");
      cyc(100);
      check(in_reset(), "R3", "reset held while supply low", rst_out_lo, 0);
   endtask

   task automatic t_powerup();
      int n;
      supply_ok = 1'b1;
      measure(1'b0, 400, n);
      check_window("R4", "release after supply valid", n, HOLD * P);
      check_pol("after release");
   endtask

   task automatic t_wd_off();
      int hits = 0;
      for (int i = 0; i < LONG * P + 40; i++) begin
         @(negedge clk);
         if (in_reset()) hits++;
      end
      check(hits == 0, "R5", "code 11 never expires", hits, 0);
   endtask

   task automatic t_brownout();
      int n;
      supply_ok = 1'b0;
      measure(1'b1, 10, n);
      check(n <= 4, "R3", "assert delay on low supply", n, 4);
      cyc(10);
      supply_ok = 1'b1;
      cyc(HOLD * P / 2);
      check(in_reset(), "R3", "still held mid-hold", rst_out_lo, 0);
      supply_ok = 1'b0;
      cyc(2);
      supply_ok = 1'b1;
      measure(1'b0, 400, n);
      check_window("R3", "release timed from final rise", n, HOLD * P);
   endtask

   task automatic t_lock_and_timeout();
      int n;
      write_cfg(3'b111);
      wait_nv();
      check(cfg_rdata == 3'b111, "R7", "unlocked write accepted", cfg_rdata, 7);
      wp_pin = 1'b1;
      write_cfg(3'b010);
      cyc(2);
      check(!nv_busy, "R7", "locked write starts no cycle", nv_busy, 0);
      cyc((NV + 1) * P);
      check(cfg_rdata == 3'b111, "R7", "locked write ignored", cfg_rdata, 7);
      wp_pin = 1'b0;
      write_cfg(3'b010);
      cyc(1);
      check(nv_busy, "R8", "write cycle running", nv_busy, 1);
      wait_nv();
      check(cfg_rdata == 3'b010, "R7", "write with pin low accepted", cfg_rdata, 2);
      measure(1'b1, 300, n);
      check_window("R2", "short interval expiry", n, SHORT * P);
      check_pol("watchdog reset");
      measure(1'b0, 300, n);
      check_window("R6", "watchdog reset hold", n, HOLD * P);
      measure(1'b1, 300, n);
      check_window("R9", "interval counted from release", n, SHORT * P);
      measure(1'b0, 300, n);
   endtask

   task automatic t_kicks();
      int hits = 0;
      for (int k = 0; k < 6; k++) begin
         start_fall();
         bus_idle();
         for (int i = 0; i < SHORT * P - 30; i++) begin
            @(negedge clk);
            if (in_reset()) hits++;
         end
      end
      check(hits == 0, "R1", "regular starts keep reset off", hits, 0);
   endtask

   task automatic t_fake_activity();
      int n;
      int elapsed = 0;
      start_fall();
      cyc(3);
      elapsed += 3;
      scl_in = 1'b0;
      for (int i = 0; i < 6; i++) begin
         sda_in = ~sda_in;
         cyc(3);
         elapsed += 3;
      end
      sda_in = 1'b0;
      cyc(2);
      scl_in = 1'b1;
      cyc(3);
      sda_in = 1'b1;
      cyc(3);
      elapsed += 8;
      measure(1'b1, 300, n);
      check_window("R1", "expiry timed from the only real start", elapsed + n, SHORT * P + 2);
      measure(1'b0, 300, n);
   endtask

   task automatic t_nv_across_reset();
      int n;
      write_cfg(3'b011);
      supply_ok = 1'b0;
      cyc(5);
      check(in_reset() && nv_busy, "R8", "write continues into reset", nv_busy, 1);
      wait_nv();
      check(cfg_rdata == 3'b011, "R8", "interrupted write committed", cfg_rdata, 3);
      write_cfg(3'b001);
      cyc(2);
      check(!nv_busy, "R8", "no write starts in reset", nv_busy, 0);
      cyc((NV + 1) * P);
      check(cfg_rdata == 3'b011, "R8", "write in reset ignored", cfg_rdata, 3);
      supply_ok = 1'b1;
      measure(1'b0, 400, n);
      check_pol("final release");
   endtask

   initial begin
      rst_n = 1'b0; supply_ok = 1'b0; scl_in = 1'b1; sda_in = 1'b1;
      wp_pin = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
      cyc(5);
      rst_n = 1'b1;
      cyc(1);
      t_reset_state();
      t_powerup();
      t_wd_off();
      t_brownout();
      t_lock_and_timeout();
      t_kicks();
      t_fake_activity();
      t_nv_across_reset();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule